// File: doc/BRIEF.md
# Segment Bound Checker

This block guards a segmented, paged address space. Each incoming 32-bit virtual address is split into a segment number, a page number inside that segment, and a byte offset. The page number is checked against the page count stored for its segment. A reference whose page lies inside the segment goes out unchanged on the output stream, ready for the page translation stage that follows. A reference past the end of its segment is not forwarded. Instead a one-cycle fault pulse is raised, carrying the offending address.

Segments are independent two-dimensional regions. Stepping past the last page of one segment never reaches page zero of the next; it is an error. Each segment has its own size. A write port lets software-facing logic resize any segment while lookups keep flowing, and a write and a lookup to the same segment in the same cycle are resolved in favour of the new size.

Both address streams use valid/ready. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. A legal result sits in the output register until the edge where `out_valid` and `out_ready` are both high. While it waits, `out_valid` and `out_addr` hold and `in_ready` is low. A fault result needs no downstream handshake: it occupies the register for exactly one cycle, and `in_ready` stays high during that cycle. The bound write port and the fault outputs are plain control and status pins.

Top module: `seg_bound_checker`

## Requirements
- R1: The address fields are split as follows: the segment number is `in_addr[31:22]`, the page number is `in_addr[21:12]` and the offset is `in_addr[11:0]`. A legal reference appears on `out_addr` with all 32 bits unchanged.
- R2: A reference is legal when its page number is strictly less than the stored page count of its segment. A legal reference produces `out_valid` high with `fault_o` low.
- R3: A reference whose page number is equal to or above its segment's count produces `fault_o` high for one cycle, with `fault_addr` equal to the address. `out_valid` stays low for it.
- R4: After reset every segment count is zero, so every segment is empty and every reference faults. After reset `out_valid` and `fault_o` are low and `in_ready` is high.
- R5: The result of a reference accepted on a clock edge is visible directly after that edge. If no reference is accepted and nothing is held, both `out_valid` and `fault_o` are low after the edge.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` hold their values on the next cycle and `in_ready` is low.
- R7: A count written on `bnd_wr_*` (11 bits, 0 to 1024) applies to every lookup accepted from the same edge on. If a lookup accepted on that edge targets the same segment, it uses the new count.
- R8: A bound write changes only the addressed segment's count.
- R9: The full count range is honoured. With a count of 1024, page 1023 is legal. With a count of 1023, page 1023 faults and page 1022 is legal.
- R10: A faulting reference is completed without `out_ready`. `in_ready` remains high while a fault is reported, and the fault clears after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_wr_en | input | 1 | Bound write strobe |
| bnd_wr_seg | input | 10 | Segment whose count is written |
| bnd_wr_count | input | 11 | New page count for that segment |
| in_valid | input | 1 | Input reference valid |
| in_ready | output | 1 | Checker can take a reference |
| in_addr | input | 32 | Virtual address of the reference |
| out_valid | output | 1 | Legal reference available |
| out_ready | input | 1 | Downstream takes the legal reference |
| out_addr | output | 32 | Legal virtual address, unchanged |
| fault_o | output | 1 | One-cycle bound violation pulse |
| fault_addr | output | 32 | Address that violated its bound |

## Verification
A corrupt count in the bound table shows up at the ports on the first reference to that segment. One cycle after acceptance, a legal page appears as a fault, or an illegal page is passed on `out_valid`. Vectors place pages exactly at and one below each written count, so an off-by-one comparison is caught. A write forwarding path that is wrong is exposed in the same cycle by lookups that coincide with a write. A wrong state in the output register shows within one cycle: a legal result that is dropped or changed under back-pressure, or a fault that lingers or blocks the input.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // occupancy of the single result register
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PASS  = 2'd1,
    ST_FAULT = 2'd2
  } stage_e;
endpackage

// File: rtl/sbc_addr_split.sv
module sbc_addr_split #(
  parameter int SEG_W  = 10,
  parameter int PAGE_W = 10,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = SEG_W + PAGE_W + OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEG_W-1:0]  seg,
  output logic [PAGE_W-1:0] page
);
  localparam int PAGE_LO = OFF_W;
  localparam int SEG_LO  = OFF_W + PAGE_W;

  always_comb begin
    seg  = addr[SEG_LO +: SEG_W];
    page = addr[PAGE_LO +: PAGE_W];
  end
endmodule

// File: rtl/sbc_bound_table.sv
module sbc_bound_table #(
  parameter int SEG_W     = 10,
  parameter int CNT_W     = 11,
  parameter int RESET_CNT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int DEPTH = 1 << SEG_W;

  logic [CNT_W-1:0] cnt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[g] <= CNT_W'(RESET_CNT);
      else if (wr_en && (wr_seg == SEG_W'(g)))
        cnt_q[g] <= wr_cnt;
    end
  end

  // a write in flight wins over the stored value for the same segment
  always_comb begin
    if (wr_en && (wr_seg == rd_seg))
      rd_cnt = wr_cnt;
    else
      rd_cnt = cnt_q[rd_seg];
  end
endmodule

// File: rtl/sbc_range_cmp.sv
module sbc_range_cmp #(
  parameter int PAGE_W = 10,
  parameter int CNT_W  = PAGE_W + 1
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  limit,
  output logic              legal
);
  always_comb legal = CNT_W'(page) < limit;
endmodule

// File: rtl/sbc_stage.sv
module sbc_stage
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_legal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              fault,
  output logic [ADDR_W-1:0] held_addr
);
  stage_e            st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  // only an unconsumed legal result blocks the input
  always_comb begin
    in_ready = (st_q != ST_PASS) || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_EMPTY;
      addr_q <= '0;
    end else if (take) begin
      st_q   <= in_legal ? ST_PASS : ST_FAULT;
      addr_q <= in_addr;
    end else if (st_q == ST_FAULT || (st_q == ST_PASS && out_ready)) begin
      st_q <= ST_EMPTY;
    end
  end

  always_comb begin
    out_valid = (st_q == ST_PASS);
    fault     = (st_q == ST_FAULT);
    held_addr = addr_q;
  end
endmodule

// File: rtl/seg_bound_checker.sv
module seg_bound_checker #(
  parameter int SEG_W     = 10,
  parameter int PAGE_W    = 10,
  parameter int OFF_W     = 12,
  parameter int RESET_CNT = 0,
  localparam int ADDR_W   = SEG_W + PAGE_W + OFF_W,
  localparam int CNT_W    = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_wr_en,
  input  logic [SEG_W-1:0]  bnd_wr_seg,
  input  logic [CNT_W-1:0]  bnd_wr_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr
);
  logic [SEG_W-1:0]  look_seg;
  logic [PAGE_W-1:0] look_page;
  logic [CNT_W-1:0]  look_cnt;
  logic              look_legal;
  logic [ADDR_W-1:0] held_addr;

  sbc_addr_split #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_split (
    .addr(in_addr), .seg(look_seg), .page(look_page)
  );

  sbc_bound_table #(
    .SEG_W(SEG_W), .CNT_W(CNT_W), .RESET_CNT(RESET_CNT)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bnd_wr_en), .wr_seg(bnd_wr_seg), .wr_cnt(bnd_wr_count),
    .rd_seg(look_seg), .rd_cnt(look_cnt)
  );

  sbc_range_cmp #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_cmp (
    .page(look_page), .limit(look_cnt), .legal(look_legal)
  );

  sbc_stage #(
    .ADDR_W(ADDR_W)
  ) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_legal(look_legal),
    .out_valid(out_valid), .out_ready(out_ready),
    .fault(fault_o), .held_addr(held_addr)
  );

  always_comb begin
    out_addr   = held_addr;
    fault_addr = held_addr;
  end
endmodule

// File: rtl/seg_bound_checker_sva.sv
module seg_bound_checker_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              fault_o
);
  AST_PASS_OR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && fault_o)); // R3

  AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || fault_o)); // R5

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> (!out_valid && !fault_o)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_FAULT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> in_ready); // R10

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !in_valid) |=> !fault_o); // R10
endmodule

bind seg_bound_checker seg_bound_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .fault_o(fault_o)
);

// File: tb/sim_seg_bound_checker.sv
`timescale 1ns/1ps
module sim_seg_bound_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bnd_wr_en;
  logic [9:0]  bnd_wr_seg;
  logic [10:0] bnd_wr_count;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_addr;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic        fault_o;
  logic [31:0] fault_addr;

  int applied = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  seg_bound_checker u0 (
    .clk(clk), .rst_n(rst_n),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_seg(bnd_wr_seg), .bnd_wr_count(bnd_wr_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .fault_o(fault_o), .fault_addr(fault_addr)
  );

  // expected kind: 0 idle, 1 pass, 2 fault
  typedef struct packed {
    logic        wr;
    logic [9:0]  wseg;
    logic [10:0] wcnt;
    logic        lk;
    logic [9:0]  seg;
    logic [9:0]  pg;
    logic [11:0] off;
    logic [1:0]  kind;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'd5,    11'd3,    1'b0, 10'd0,    10'd0,    12'h000, 2'd0, 4'd5},  // R5 idle write
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd5,    10'd2,    12'h123, 2'd1, 4'd2},  // R2
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd5,    10'd3,    12'h010, 2'd2, 4'd3},  // R3
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd6,    10'd0,    12'h000, 2'd2, 4'd8},  // R8
    '{1'b1, 10'd6,    11'd1,    1'b1, 10'd6,    10'd0,    12'h7ff, 2'd1, 4'd7},  // R7
    '{1'b1, 10'd5,    11'd2,    1'b1, 10'd5,    10'd2,    12'h001, 2'd2, 4'd7},  // R7
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd5,    10'd1,    12'habc, 2'd1, 4'd1},  // R1
    '{1'b1, 10'd1023, 11'd1024, 1'b0, 10'd0,    10'd0,    12'h000, 2'd0, 4'd5},  // R5
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd1023, 10'd1023, 12'hfff, 2'd1, 4'd9},  // R9
    '{1'b1, 10'd1023, 11'd1023, 1'b1, 10'd1023, 10'd1023, 12'h000, 2'd2, 4'd9},  // R9
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd1023, 10'd1022, 12'h555, 2'd1, 4'd9},  // R9
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd0,    10'd0,    12'h000, 2'd2, 4'd4},  // R4
    '{1'b1, 10'd7,    11'd5,    1'b1, 10'd8,    10'd0,    12'h000, 2'd2, 4'd8},  // R8
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd7,    10'd4,    12'h0f0, 2'd1, 4'd2},  // R2
    '{1'b0, 10'd0,    11'd0,    1'b1, 10'd5,    10'd0,    12'hfff, 2'd1, 4'd1}   // R1
  };

  function automatic logic [31:0] mk(input logic [9:0] s, input logic [9:0] p,
                                     input logic [11:0] o);
    return {s, p, o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bnd_wr_en = 1'b0; bnd_wr_seg = '0; bnd_wr_count = '0;
    in_valid = 1'b0; in_addr = '0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R4: reset state at the ports
    chk("R4 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R4 fault_o after reset",   32'(fault_o),   32'd0);
    chk("R4 in_ready after reset",  32'(in_ready),  32'd1);

    // vector table walk, full throughput
    for (int i = 0; i < NV; i++) begin
      bnd_wr_en    = VECS[i].wr;
      bnd_wr_seg   = VECS[i].wseg;
      bnd_wr_count = VECS[i].wcnt;
      in_valid     = VECS[i].lk;
      in_addr      = mk(VECS[i].seg, VECS[i].pg, VECS[i].off);
      out_ready    = 1'b1;
      @(negedge clk);
      begin
        string tag;
        tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
        chk({tag, " out_valid"}, 32'(out_valid), 32'(VECS[i].kind == 2'd1));
        chk({tag, " fault_o"},   32'(fault_o),   32'(VECS[i].kind == 2'd2));
        if (VECS[i].kind == 2'd1)
          chk({tag, " out_addr"}, out_addr, mk(VECS[i].seg, VECS[i].pg, VECS[i].off));
        if (VECS[i].kind == 2'd2)
          chk({tag, " fault_addr"}, fault_addr, mk(VECS[i].seg, VECS[i].pg, VECS[i].off));
      end
    end
    idle_inputs();
    @(negedge clk);

    // R6: back-pressure on a legal result (segment 7 holds 5 pages)
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_addr   = mk(10'd7, 10'd0, 12'h111);
    @(negedge clk);
    chk("R6 out_valid stalled", 32'(out_valid), 32'd1);
    chk("R6 in_ready stalled",  32'(in_ready),  32'd0);
    chk("R6 out_addr first",    out_addr, mk(10'd7, 10'd0, 12'h111));
    in_addr = mk(10'd7, 10'd1, 12'h222);
    @(negedge clk);
    chk("R6 out_addr held",  out_addr, mk(10'd7, 10'd0, 12'h111));
    chk("R6 out_valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R6 second accepted on release", out_addr, mk(10'd7, 10'd1, 12'h222));
    chk("R6 second valid", 32'(out_valid), 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5 drained", 32'(out_valid), 32'd0);

    // R10: a fault completes while the output is stalled
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_addr   = mk(10'd7, 10'd9, 12'h333);
    @(negedge clk);
    chk("R10 fault raised",        32'(fault_o),   32'd1);
    chk("R10 fault address",       fault_addr,     mk(10'd7, 10'd9, 12'h333));
    chk("R10 in_ready during fault", 32'(in_ready), 32'd1);
    chk("R10 no out_valid",        32'(out_valid), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 fault cleared", 32'(fault_o), 32'd0);

    // R3: faults back to back stay one per reference
    in_valid = 1'b1;
    in_addr  = mk(10'd8, 10'd0, 12'h000);
    @(negedge clk);
    in_addr  = mk(10'd6, 10'd1, 12'h444);
    @(negedge clk);
    chk("R3 second fault address", fault_addr, mk(10'd6, 10'd1, 12'h444));
    chk("R3 second fault raised",  32'(fault_o), 32'd1);
    idle_inputs();
    @(negedge clk);
    chk("R3 fault one cycle", 32'(fault_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule